// File: doc/BRIEF.md
# Power Mode Clock Controller

This block sequences the operating power state of a processor and turns each state into the clock and power control levels around it. It drives the PLL enable, the PLL bypass select, the core clock enable, the system clock enable and the core supply enable. It also holds the input-to-core multiplier ratio that the clock generator uses. Software moves the block between states with a one-cycle request strobe that carries a mode code. A wake-up event brings it back out of the two sleeping states. The PLL, the regulator and the analog lock detector sit outside the block. The lock indication comes in as an asynchronous level and passes through a synchronizer whose depth is a parameter.

A new multiplier ratio that is written while the core is not in Full On is kept aside. It reaches the ratio output only when Full On is entered. When Full On is re-entered from a state with the PLL switched off, the bypass select stays asserted until the synchronized lock is seen. Any request that arrives during that wait is dropped and sets a sticky error flag. Hibernate removes core power, and only a reset leaves it.

Top module: `pwr_mode_ctl`

## Requirements
- R1: During and after reset, `cur_mode` is 0 (Full On), `pll_en`=1, `pll_bypass`=0, `cclk_en`=1, `sclk_en`=1, `core_pwr_en`=1, `ratio_q` equals `RATIO_RST` and `req_err`=0.
- R2: The mode codes on `cur_mode` are 0 Full On, 1 Active, 2 Sleep, 3 Deep Sleep and 4 Hibernate. The outputs {pll_en, pll_bypass, cclk_en, sclk_en, core_pwr_en} are:
  - Active: 1,1,1,1,1.
  - Sleep: 1,b,0,1,1, where b is 1 only if Sleep was entered from Active.
  - Deep Sleep: 0,1,0,0,1.
  - Hibernate: 0,1,0,0,0.
  - Full On: 1,w,1,1,1, where w is 1 only while the lock wait of R7 is pending.
- R3: A `ratio_wr` in any mode other than Full On leaves `ratio_q` unchanged. The last value written is loaded into `ratio_q` on the same edge that makes `cur_mode` Full On.
- R4: A `ratio_wr` in Full On loads `ratio_in` into `ratio_q` on that clock edge.
- R5: In Full On or Active, a `req_valid` strobe with a mode code from 0 to 4 that differs from the current mode changes `cur_mode` to that code on the same edge. Entering Sleep or Deep Sleep records the mode it came from.
- R6: `wake` in Sleep or Deep Sleep returns `cur_mode` to the recorded mode on that edge. `wake` in Full On, Active or Hibernate has no effect.
- R7: A wake from Deep Sleep into Full On holds `pll_bypass` at 1. It drops on the edge after `pll_lock`, delayed by `LOCK_STAGES` flops, is seen high. With `LOCK_STAGES`=2, `pll_bypass` falls on the third edge at which `pll_lock` is high.
- R8: A `req_valid` strobe while the lock wait of R7 is pending is ignored. It sets `req_err`, which stays 1 until reset.
- R9: Hibernate is left only through reset. Requests and `wake` leave `cur_mode` at 4.
- R10: Requests made in Sleep or Deep Sleep are ignored. Requests with mode codes 5 to 7 are ignored and do not set `req_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 3 | Requested mode code |
| wake | input | 1 | Wake-up event |
| ratio_wr | input | 1 | Multiplier ratio write strobe |
| ratio_in | input | RATIO_W | Multiplier ratio to write |
| pll_lock | input | 1 | Asynchronous PLL lock level |
| pll_en | output | 1 | PLL enable |
| pll_bypass | output | 1 | PLL bypass select |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| core_pwr_en | output | 1 | Core supply enable |
| ratio_q | output | RATIO_W | Multiplier ratio in use |
| cur_mode | output | 3 | Current mode code |
| req_err | output | 1 | Sticky dropped-request flag |

## Verification
The assertions assume that `wake`, `req_valid` and `ratio_wr` are synchronous to `clk` and are free of X once reset is released. Only `pll_lock` may change without regard to the clock. The stimulus therefore changes every input on the falling edge, with `pll_lock` included. It holds each strobe for exactly one cycle, and it makes no ratio write in the same cycle as a mode change into Full On.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [2:0] {
      PM_FULL   = 3'd0,
      PM_ACTIVE = 3'd1,
      PM_SLEEP  = 3'd2,
      PM_DEEP   = 3'd3,
      PM_HIBER  = 3'd4
   } pm_mode_e;

   localparam int PM_MODE_W    = 3;
   localparam int PM_NUM_MODES = 5;

   typedef struct packed {
      logic pll_en;
      logic pll_byp;
      logic cclk_en;
      logic sclk_en;
      logic pwr_en;
   } pm_ctl_t;

   function automatic logic pm_is_sleeping(pm_mode_e m);
      return (m == PM_SLEEP) || (m == PM_DEEP);
   endfunction

   function automatic logic pm_is_running(pm_mode_e m);
      return (m == PM_FULL) || (m == PM_ACTIVE);
   endfunction

endpackage

// File: rtl/pwr_lock_sync.sv
module pwr_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_in,
   output logic lock_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign lock_out = lock_in;
      end else begin : g_chain
         logic [STAGES-1:0] stage_q;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[i] <= 1'b0;
                  else        stage_q[i] <= lock_in;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[i] <= 1'b0;
                  else        stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign lock_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [PM_MODE_W-1:0] req_mode,
   input  logic                 wake,
   input  logic                 lock_s,
   output pm_mode_e             mode_q,
   output pm_mode_e             prev_q,
   output logic                 relock_q,
   output logic                 err_q,
   output logic                 enter_full
);

   pm_mode_e nxt_mode;
   pm_mode_e nxt_prev;
   logic     nxt_relock;
   logic     nxt_err;
   logic     code_ok;
   logic     accept;
   logic     wake_hit;

   assign code_ok  = (int'(req_mode) < PM_NUM_MODES);
   assign accept   = req_valid && !relock_q && pm_is_running(mode_q) &&
                     code_ok && (req_mode != mode_q);
   assign wake_hit = wake && pm_is_sleeping(mode_q);

   always_comb begin
      nxt_mode   = mode_q;
      nxt_prev   = prev_q;
      nxt_relock = relock_q && !lock_s;
      nxt_err    = err_q || (req_valid && relock_q);
      if (accept) begin
         nxt_mode = pm_mode_e'(req_mode);
         if (pm_is_sleeping(pm_mode_e'(req_mode))) nxt_prev = mode_q;
      end else if (wake_hit) begin
         nxt_mode = prev_q;
         if ((mode_q == PM_DEEP) && (prev_q == PM_FULL)) nxt_relock = 1'b1;
      end
   end

   assign enter_full = (nxt_mode == PM_FULL) && (mode_q != PM_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= PM_FULL;
         prev_q   <= PM_FULL;
         relock_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         mode_q   <= nxt_mode;
         prev_q   <= nxt_prev;
         relock_q <= nxt_relock;
         err_q    <= nxt_err;
      end
   end

endmodule

// File: rtl/pwr_ratio_hold.sv
module pwr_ratio_hold #(
   parameter int W   = 6,
   parameter int RST = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         in_full,
   input  logic         enter_full,
   output logic [W-1:0] ratio_q
);

   localparam logic [W-1:0] RST_V = W'(RST);

   logic [W-1:0] pend_q;
   logic [W-1:0] pend_nxt;

   assign pend_nxt = wr ? wdata : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= RST_V;
         ratio_q <= RST_V;
      end else begin
         pend_q <= pend_nxt;
         if (in_full && wr)  ratio_q <= wdata;
         else if (enter_full) ratio_q <= pend_nxt;
      end
   end

endmodule

// File: rtl/pwr_clk_decode.sv
module pwr_clk_decode
   import pwr_mode_pkg::*;
(
   input  pm_mode_e mode,
   input  pm_mode_e prev,
   input  logic     relock,
   output pm_ctl_t  ctl
);

   always_comb begin
      ctl = '{pll_en: 1'b1, pll_byp: 1'b0, cclk_en: 1'b1, sclk_en: 1'b1, pwr_en: 1'b1};
      unique case (mode)
         PM_FULL:   ctl.pll_byp = relock;
         PM_ACTIVE: ctl.pll_byp = 1'b1;
         PM_SLEEP: begin
            ctl.pll_byp = (prev == PM_ACTIVE);
            ctl.cclk_en = 1'b0;
         end
         PM_DEEP: begin
            ctl.pll_en  = 1'b0;
            ctl.pll_byp = 1'b1;
            ctl.cclk_en = 1'b0;
            ctl.sclk_en = 1'b0;
         end
         PM_HIBER: begin
            ctl.pll_en  = 1'b0;
            ctl.pll_byp = 1'b1;
            ctl.cclk_en = 1'b0;
            ctl.sclk_en = 1'b0;
            ctl.pwr_en  = 1'b0;
         end
         default: ctl = '{pll_en: 1'b0, pll_byp: 1'b1, cclk_en: 1'b0, sclk_en: 1'b0, pwr_en: 1'b0};
      endcase
   end

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
   import pwr_mode_pkg::*;
#(
   parameter int RATIO_W     = 6,
   parameter int RATIO_RST   = 10,
   parameter int LOCK_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [2:0]         req_mode,
   input  logic               wake,
   input  logic               ratio_wr,
   input  logic [RATIO_W-1:0] ratio_in,
   input  logic               pll_lock,
   output logic               pll_en,
   output logic               pll_bypass,
   output logic               cclk_en,
   output logic               sclk_en,
   output logic               core_pwr_en,
   output logic [RATIO_W-1:0] ratio_q,
   output logic [2:0]         cur_mode,
   output logic               req_err
);

   localparam int RATIO_MAX = (1 << RATIO_W) - 1;

   generate
      if (RATIO_W < 1 || RATIO_W > 16) begin : g_bad_width
         $error("pwr_mode_ctl: RATIO_W out of range");
      end
      if (RATIO_RST < 0 || RATIO_RST > RATIO_MAX) begin : g_bad_reset
         $error("pwr_mode_ctl: RATIO_RST does not fit RATIO_W");
      end
      if (LOCK_STAGES < 0 || LOCK_STAGES > 8) begin : g_bad_sync
         $error("pwr_mode_ctl: LOCK_STAGES out of range");
      end
   endgenerate

   logic     lock_s;
   pm_mode_e mode_q;
   pm_mode_e prev_q;
   logic     relock_q;
   logic     err_q;
   logic     enter_full;
   pm_ctl_t  ctl;

   pwr_lock_sync #(.STAGES(LOCK_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_in  (pll_lock),
      .lock_out (lock_s)
   );

   pwr_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_mode   (req_mode),
      .wake       (wake),
      .lock_s     (lock_s),
      .mode_q     (mode_q),
      .prev_q     (prev_q),
      .relock_q   (relock_q),
      .err_q      (err_q),
      .enter_full (enter_full)
   );

   pwr_ratio_hold #(.W(RATIO_W), .RST(RATIO_RST)) u_ratio (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (ratio_wr),
      .wdata      (ratio_in),
      .in_full    (mode_q == PM_FULL),
      .enter_full (enter_full),
      .ratio_q    (ratio_q)
   );

   pwr_clk_decode u_dec (
      .mode   (mode_q),
      .prev   (prev_q),
      .relock (relock_q),
      .ctl    (ctl)
   );

   assign pll_en      = ctl.pll_en;
   assign pll_bypass  = ctl.pll_byp;
   assign cclk_en     = ctl.cclk_en;
   assign sclk_en     = ctl.sclk_en;
   assign core_pwr_en = ctl.pwr_en;
   assign cur_mode    = mode_q;
   assign req_err     = err_q;

endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
   parameter int RATIO_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               wake,
   input logic               pll_en,
   input logic               pll_bypass,
   input logic               cclk_en,
   input logic               sclk_en,
   input logic               core_pwr_en,
   input logic [RATIO_W-1:0] ratio_q,
   input logic [2:0]         cur_mode,
   input logic               req_err
);

   assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cur_mode <= 3'd4);

   assert_active_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd1) |-> (pll_en && pll_bypass && cclk_en && sclk_en && core_pwr_en));

   assert_sleep_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd2) |-> (pll_en && !cclk_en && sclk_en && core_pwr_en));

   assert_deep_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd3) |-> (!pll_en && !cclk_en && !sclk_en && core_pwr_en));

   assert_ratio_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode != 3'd0) |=> ($stable(ratio_q) || (cur_mode == 3'd0)));

   assert_wake_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !req_valid && (cur_mode <= 3'd1)) |=> $stable(cur_mode));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |=> req_err);

   assert_hiber_stuck_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd4) |=> ((cur_mode == 3'd4) && !core_pwr_en));

endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.RATIO_W(RATIO_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .wake        (wake),
   .pll_en      (pll_en),
   .pll_bypass  (pll_bypass),
   .cclk_en     (cclk_en),
   .sclk_en     (sclk_en),
   .core_pwr_en (core_pwr_en),
   .ratio_q     (ratio_q),
   .cur_mode    (cur_mode),
   .req_err     (req_err)
);

// File: tb/pwr_mode_ctl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctl_test;

   localparam int RW  = 6;
   localparam int RST = 10;
   localparam int LS  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_mode = 3'd0;
   logic          wake = 1'b0;
   logic          ratio_wr = 1'b0;
   logic [RW-1:0] ratio_in = '0;
   logic          pll_lock = 1'b0;
   logic          pll_en, pll_bypass, cclk_en, sclk_en, core_pwr_en, req_err;
   logic [RW-1:0] ratio_q;
   logic [2:0]    cur_mode;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   pwr_mode_ctl #(.RATIO_W(RW), .RATIO_RST(RST), .LOCK_STAGES(LS)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .wake(wake), .ratio_wr(ratio_wr), .ratio_in(ratio_in), .pll_lock(pll_lock),
      .pll_en(pll_en), .pll_bypass(pll_bypass), .cclk_en(cclk_en), .sclk_en(sclk_en),
      .core_pwr_en(core_pwr_en), .ratio_q(ratio_q), .cur_mode(cur_mode), .req_err(req_err)
   );

   // behavioural reference model
   int m_mode, m_prev, m_ratio, m_pend;
   bit m_relock, m_err;
   bit lockq[$];

   task automatic model_reset();
      m_mode = 0; m_prev = 0; m_ratio = RST; m_pend = RST;
      m_relock = 0; m_err = 0;
      lockq.delete();
      for (int i = 0; i < LS; i++) lockq.push_back(1'b0);
   endtask

   function automatic logic [4:0] exp_ctl(int md, int pv, bit rl);
      case (md)
         0: return {1'b1, rl, 3'b111};
         1: return 5'b11111;
         2: return {1'b1, (pv == 1), 3'b011};
         3: return 5'b01001;
         default: return 5'b01000;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else begin
         bit ls;
         bit old_rl;
         int nmode;
         int npend;
         ls = lockq.pop_front();
         lockq.push_back(pll_lock);
         old_rl = m_relock;
         nmode  = m_mode;
         npend  = ratio_wr ? int'(ratio_in) : m_pend;
         if (m_relock && ls) m_relock = 0;
         if (req_valid && old_rl) m_err = 1;
         if (req_valid && !old_rl && m_mode <= 1 && req_mode <= 4 && int'(req_mode) != m_mode) begin
            nmode = req_mode;
            if (nmode == 2 || nmode == 3) m_prev = m_mode;
         end else if (wake && (m_mode == 2 || m_mode == 3)) begin
            nmode = m_prev;
            if (m_mode == 3 && m_prev == 0) m_relock = 1;
         end
         if (m_mode == 0 && ratio_wr) m_ratio = ratio_in;
         else if (nmode == 0 && m_mode != 0) m_ratio = npend;
         m_pend = npend;
         m_mode = nmode;
      end
   end

   task automatic chk(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // compare against the model on every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 mode vs model", cur_mode, m_mode);
         chk("R2 controls vs model", {pll_en, pll_bypass, cclk_en, sclk_en, core_pwr_en},
             exp_ctl(m_mode, m_prev, m_relock));
         chk("R3 ratio vs model", ratio_q, m_ratio);
         chk("R8 err vs model", req_err, m_err);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic request(int m);
      @(negedge clk); req_valid = 1'b1; req_mode = 3'(m);
      @(negedge clk); req_valid = 1'b0;
   endtask

   task automatic do_wake();
      @(negedge clk); wake = 1'b1;
      @(negedge clk); wake = 1'b0;
   endtask

   task automatic write_ratio(int v);
      @(negedge clk); ratio_wr = 1'b1; ratio_in = RW'(v);
      @(negedge clk); ratio_wr = 1'b0;
   endtask

   task automatic outs(string tag, logic [4:0] exp);
      chk(tag, {pll_en, pll_bypass, cclk_en, sclk_en, core_pwr_en}, exp);
   endtask

   initial begin
      model_reset();
      idle(3);
      chk("R1 mode in reset", cur_mode, 0);
      outs("R1 controls in reset", 5'b10111);
      @(negedge clk); rst_n = 1'b1;
      idle(1);
      chk("R1 ratio after reset", ratio_q, RST);
      chk("R1 err after reset", req_err, 0);

      write_ratio(20);
      chk("R4 write in full on", ratio_q, 20);

      request(1);
      chk("R5 enter active", cur_mode, 1);
      outs("R2 active controls", 5'b11111);
      write_ratio(33);
      idle(2);
      chk("R3 ratio held in active", ratio_q, 20);

      request(2);
      chk("R5 sleep from active", cur_mode, 2);
      outs("R2 sleep from active", 5'b11011);
      request(3);
      chk("R10 request in sleep ignored", cur_mode, 2);
      do_wake();
      chk("R6 wake to active", cur_mode, 1);
      chk("R3 ratio still held", ratio_q, 20);

      request(0);
      chk("R3 pending ratio applied on full on", ratio_q, 33);
      chk("R5 back to full on", cur_mode, 0);
      outs("R2 full on controls", 5'b10111);

      do_wake();
      chk("R6 wake in full on ignored", cur_mode, 0);
      request(6);
      chk("R10 invalid code ignored", cur_mode, 0);
      chk("R10 invalid code no error", req_err, 0);

      request(2);
      outs("R2 sleep from full on", 5'b10011);
      do_wake();
      chk("R6 wake to full on", cur_mode, 0);

      pll_lock = 1'b0;
      request(3);
      chk("R5 enter deep sleep", cur_mode, 3);
      outs("R2 deep sleep controls", 5'b01001);
      do_wake();
      chk("R6 wake from deep", cur_mode, 0);
      chk("R7 bypass held at entry", pll_bypass, 1);
      idle(4);
      chk("R7 bypass held without lock", pll_bypass, 1);
      request(1);
      chk("R8 request during wait ignored", cur_mode, 0);
      chk("R8 error set", req_err, 1);

      @(negedge clk); pll_lock = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R7 bypass still held two edges later", pll_bypass, 1);
      @(negedge clk);
      chk("R7 bypass released after sync", pll_bypass, 0);
      idle(3);
      chk("R8 error sticky", req_err, 1);

      request(1);
      request(4);
      chk("R9 enter hibernate", cur_mode, 4);
      outs("R2 hibernate controls", 5'b01000);
      do_wake();
      request(0);
      chk("R9 hibernate kept", cur_mode, 4);

      @(negedge clk); rst_n = 1'b0;
      idle(2);
      @(negedge clk); rst_n = 1'b1;
      idle(1);
      chk("R1 mode after second reset", cur_mode, 0);
      chk("R1 err cleared by reset", req_err, 0);
      chk("R1 ratio after second reset", ratio_q, RST);
      idle(2);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule